// File: doc/BRIEF.md
# Stack Push Datapath and Sequencer

This block executes a single register push onto a memory stack using a small non-pipelined datapath. It contains two 8-bit general registers, a 16-bit stack pointer, a 16-bit address latch and an 8-bit data latch. One 2:1 multiplexer steers either general register onto a shared 8-bit bus, and a sequencer steps the push through a fixed five-cycle timeline: an instruction fetch slot, a decode and register read cycle, a two-cycle memory write, and a stack pointer decrement.

A push is requested with a one-cycle `start` and a one-bit `push_sel`. The write goes to the address held in the stack pointer before the decrement. The memory side is a plain synchronous write port, and `done` marks the end of each push. The general registers are loaded through a small write port so that the surrounding logic can set the values that will be pushed.

Top module: `stack_push_top`

## Requirements
- R1: A synchronous active-low reset leaves the block idle, with `busy`, `done` and `mem_we` low and `sp` equal to the parameter `SP_INIT`. This also applies when reset arrives in the middle of a push.
- R2: When `reg_we` is high at a clock edge, `reg_wdata` is stored in register A if `reg_wsel` is 0 and in register B if `reg_wsel` is 1.
- R3: A push writes the selected register (A when `push_sel` is 0, B when it is 1) to `mem_addr` equal to the stack pointer value from before the push.
- R4: `mem_we` is high for exactly two consecutive cycles per push, and `mem_addr` and `mem_wdata` do not change across those two cycles.
- R5: The stack pointer decreases by exactly one per push and changes only at the end of the decrement cycle, the fifth cycle.
- R6: After `start` is accepted at edge E0, `busy` is high from E0 to E5, and `mem_we` is high only between E2 and E4.
- R7: `done` is high for exactly one cycle, the cycle after the decrement cycle. At that point `busy` is already low.
- R8: `start` and `push_sel` are ignored while `busy` is high. The push in progress keeps the register chosen when it was accepted, and no second push begins.
- R9: A decrement from 0x0000 wraps the stack pointer to 0xFFFF.
- R10: A `start` given in the cycle in which `done` is high is accepted, so pushes can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | General register write strobe |
| reg_wsel | input | 1 | Target register for the write: 0 = A, 1 = B |
| reg_wdata | input | 8 | Value to write into the general register |
| start | input | 1 | Push request, sampled while idle |
| push_sel | input | 1 | Register to push: 0 = A, 1 = B |
| mem_addr | output | 16 | Memory write address, taken from the address latch |
| mem_wdata | output | 8 | Memory write data, taken from the data latch |
| mem_we | output | 1 | Memory write enable |
| busy | output | 1 | High while a push is in progress |
| done | output | 1 | One-cycle pulse at the end of a push |
| sp | output | 16 | Current stack pointer |

## Verification
Let E0 be the clock edge at which `start` is sampled while idle. `busy` goes high after E0. The address and data latches load at E2, and the write enable is high during the two cycles that follow E2 and E3. The stack pointer and `done` change at E5. The bench drives inputs on falling edges and then reads each output at the falling edge one, two, three, four or five edges after E0, matching the register count on the path to that output. The checks for ignored requests and for the end of the pulse are made one falling edge after E5.

// File: rtl/stack_push_pkg.sv
// Package: shared types for the stack push block.
// Assumes a single push sequence with no overlap between pushes.
package stack_push_pkg;

    // Sequencer phases, in the order they are visited.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_DECODE = 3'd2,
        ST_WR1    = 3'd3,
        ST_WR2    = 3'd4,
        ST_SPDEC  = 3'd5
    } push_state_e;

endpackage

// File: rtl/push_sequencer.sv
// Module: push_sequencer
// Steps one push through fetch, decode/read, two write cycles and an SP
// decrement, then pulses done. Starts are accepted only in the idle phase.
// Assumes start is synchronous to clk.
module push_sequencer
    import stack_push_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ld_sel,
    output logic ld_xfer,
    output logic mem_we,
    output logic sp_dec,
    output logic busy,
    output logic done
);

    push_state_e state_q, state_d;
    logic        done_q;

    // Next-phase selection: a fixed walk once a start is taken.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (start) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_WR1;
            ST_WR1:    state_d = ST_WR2;
            ST_WR2:    state_d = ST_SPDEC;
            ST_SPDEC:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Phase register and done pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_SPDEC);
        end
    end

    // Control strobes decoded from the current phase.
    assign ld_sel  = (state_q == ST_IDLE) && start;
    assign ld_xfer = (state_q == ST_DECODE);
    assign mem_we  = (state_q == ST_WR1) || (state_q == ST_WR2);
    assign sp_dec  = (state_q == ST_SPDEC);
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;

    // R6: each phase hands over to the next one
    a_r6_fetch_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE));
    a_r6_wr1_to_wr2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR1) |=> (state_q == ST_WR2) && mem_we);
    // R4: the write enable drops after its second cycle
    a_r4_we_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR2) |=> !mem_we);
    // R8: no new fetch can follow a busy phase
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state_q != ST_FETCH));
    // R7: done follows the decrement cycle and lasts one cycle
    a_r7_done_after_dec: assert property (@(posedge clk) disable iff (!rst_n)
        sp_dec |=> done && !busy);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/push_datapath.sv
// Module: push_datapath
// Holds the general registers, the bus multiplexer, the address and data
// latches and the stack pointer with its own decrementer.
// Assumes the control strobes come from push_sequencer, one phase at a time.
module push_datapath #(
    parameter int          DATA_W  = 8,
    parameter int          ADDR_W  = 16,
    parameter int          NREG    = 2,
    parameter logic [15:0] SP_INIT = 16'h0100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [$clog2(NREG)-1:0] reg_wsel,
    input  logic [DATA_W-1:0]       reg_wdata,
    input  logic [$clog2(NREG)-1:0] push_sel,
    input  logic                    ld_sel,
    input  logic                    ld_xfer,
    input  logic                    sp_dec,
    input  logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic [ADDR_W-1:0]       sp
);

    localparam int SEL_W = $clog2(NREG);

    logic [DATA_W-1:0] gp_q [NREG];
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] bus;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mdr_q;
    logic [ADDR_W-1:0] sp_q;

    // General registers, one write decoder per register.
    for (genvar g = 0; g < NREG; g++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (!rst_n)
                gp_q[g] <= '0;
            else if (reg_we && (reg_wsel == SEL_W'(g)))
                gp_q[g] <= reg_wdata;
        end
    end

    // Register select captured when a push is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (ld_sel)
            sel_q <= push_sel;
    end

    // Bus multiplexer: the chosen register drives the shared bus.
    assign bus = gp_q[sel_q];

    // Address and data latches: SP feeds the address latch, the bus feeds the data latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
            mdr_q <= '0;
        end else if (ld_xfer) begin
            mar_q <= sp_q;
            mdr_q <= bus;
        end
    end

    // Stack pointer with its own decrementer; wraps silently at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= ADDR_W'(SP_INIT);
        else if (sp_dec)
            sp_q <= sp_q - 1'b1;
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign sp        = sp_q;

    // R3: the address latch takes the SP value from before the decrement
    a_r3_addr_from_sp: assert property (@(posedge clk) disable iff (!rst_n)
        ld_xfer |=> (mar_q == $past(sp_q)));
    // R4: address and data hold across the second write cycle
    a_r4_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mem_we && $past(mem_we)) |-> ($stable(mar_q) && $stable(mdr_q)));
    // R5: SP only ever moves down by one
    a_r5_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (sp_q != $past(sp_q))) |-> (sp_q == ADDR_W'($past(sp_q) - 1'b1)));
    // R5: SP holds while no decrement is requested
    a_r5_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_dec |=> $stable(sp_q));

endmodule

// File: rtl/stack_push_top.sv
// Module: stack_push_top
// Top of the push block: connects the sequencer to the datapath and
// exposes the memory write port. Assumes two general registers.
module stack_push_top #(
    parameter int          DATA_W  = 8,
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] SP_INIT = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_wsel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              start,
    input  logic              push_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] sp
);

    localparam int NREG = 2;

    logic ld_sel;
    logic ld_xfer;
    logic sp_dec;

    // Control sequencer.
    push_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ld_sel  (ld_sel),
        .ld_xfer (ld_xfer),
        .mem_we  (mem_we),
        .sp_dec  (sp_dec),
        .busy    (busy),
        .done    (done)
    );

    // Registers, bus and stack pointer.
    push_datapath #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NREG    (NREG),
        .SP_INIT (SP_INIT)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wsel  (reg_wsel),
        .reg_wdata (reg_wdata),
        .push_sel  (push_sel),
        .ld_sel    (ld_sel),
        .ld_xfer   (ld_xfer),
        .sp_dec    (sp_dec),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sp        (sp)
    );

    // R1: nothing is in flight in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_we && (sp == ADDR_W'(SP_INIT))));

endmodule

// File: tb/tb_stack_push_top.sv
`timescale 1ns/1ps
module tb_stack_push_top;

    localparam real         HALF    = 2.5;
    localparam logic [15:0] SP_INIT = 16'h0004;
    localparam int          NVEC    = 8;
    localparam int          WD_CYC  = 20000;

    // Vector table: {push_sel, value for A, value for B}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'h5A, 8'hC3},
        {1'b1, 8'h11, 8'hEE},
        {1'b0, 8'hFF, 8'h00},
        {1'b1, 8'h80, 8'h7F},
        {1'b0, 8'h3C, 8'hA5},
        {1'b1, 8'h01, 8'h02},
        {1'b1, 8'h96, 8'h69},
        {1'b0, 8'h00, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_wsel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        start = 1'b0;
    logic        push_sel = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        busy;
    logic        done;
    logic [15:0] sp;

    int          n_run = 0;
    int          n_fail = 0;
    logic [15:0] sp_model;

    always #(HALF) clk = ~clk;

    stack_push_top #(.SP_INIT(SP_INIT)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wsel(reg_wsel),
        .reg_wdata(reg_wdata), .start(start), .push_sel(push_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .busy(busy), .done(done), .sp(sp)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Loads one general register; begins and ends at a falling edge.
    task automatic load_reg(input logic which, input logic [7:0] val);
        reg_we = 1'b1; reg_wsel = which; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Runs one push and checks every cycle; begins and ends at a falling edge.
    task automatic do_push(input logic sel, input bit noisy, input logic [7:0] exp_data);
        logic [15:0] old_sp = sp_model;
        start = 1'b1; push_sel = sel;
        @(negedge clk);                       // after E0: fetch
        start = noisy; push_sel = noisy ? ~sel : sel;
        chk(busy == 1'b1, "R6 busy after accept", busy, 1);
        chk(mem_we == 1'b0, "R6 no write in fetch", mem_we, 0);
        @(negedge clk);                       // after E1: decode
        chk(mem_we == 1'b0, "R6 no write in decode", mem_we, 0);
        @(negedge clk);                       // after E2: first write cycle
        chk(mem_we == 1'b1, "R4 write cycle one", mem_we, 1);
        chk(mem_addr == old_sp, "R3 address is old SP", mem_addr, old_sp);
        chk(mem_wdata == exp_data, noisy ? "R8 data keeps accepted select" : "R3 data", mem_wdata, exp_data);
        @(negedge clk);                       // after E3: second write cycle
        chk(mem_we == 1'b1, "R4 write cycle two", mem_we, 1);
        chk(mem_addr == old_sp && mem_wdata == exp_data, "R4 stable address/data",
            {mem_wdata, mem_addr}, {exp_data, old_sp});
        @(negedge clk);                       // after E4: decrement cycle
        chk(mem_we == 1'b0, "R4 write ends after two cycles", mem_we, 0);
        chk(sp == old_sp, "R5 SP unchanged before decrement", sp, old_sp);
        chk(busy == 1'b1, "R6 busy in decrement cycle", busy, 1);
        @(negedge clk);                       // after E5: done
        start = 1'b0;
        sp_model = old_sp - 16'd1;
        chk(done == 1'b1, "R7 done after decrement", done, 1);
        chk(busy == 1'b0, "R6 busy clear at done", busy, 0);
        chk(sp == sp_model, "R5 SP decremented by one", sp, sp_model);
        if (old_sp == 16'h0000)
            chk(sp == 16'hFFFF, "R9 SP wraps to FFFF", sp, 16'hFFFF);
        if (noisy) begin
            @(negedge clk);
            chk(busy == 1'b0 && done == 1'b0, "R8 held start not taken, R7 done ends",
                {busy, done}, 0);
        end
    endtask

    initial begin
        #(WD_CYC * 2 * HALF);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        sp_model = SP_INIT;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_we, "R1 idle in reset", {busy, done, mem_we}, 0);
        chk(sp == SP_INIT, "R1 SP loads initial value", sp, SP_INIT);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R3, R9: table walk; SP passes 0 and wraps within the table
        for (int i = 0; i < NVEC; i++) begin
            load_reg(1'b0, VEC[i][15:8]);
            load_reg(1'b1, VEC[i][7:0]);
            do_push(VEC[i][16], 1'b0, VEC[i][16] ? VEC[i][7:0] : VEC[i][15:8]);
            @(negedge clk);
            chk(done == 1'b0, "R7 done lasts one cycle", done, 0);
        end

        // R2: overwrite only A, B keeps its value
        load_reg(1'b0, 8'h42);
        do_push(1'b1, 1'b0, VEC[NVEC-1][7:0]);
        do_push(1'b0, 1'b0, 8'h42);           // R10: started in the done cycle

        // R8: start held high with the other select during the push
        load_reg(1'b1, 8'hB7);
        do_push(1'b1, 1'b1, 8'hB7);

        // R1: reset in the middle of a push
        start = 1'b1; push_sel = 1'b0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);                       // write cycle in progress
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_we && !done, "R1 mid-push reset idles", {busy, mem_we, done}, 0);
        chk(sp == SP_INIT, "R1 mid-push reset reloads SP", sp, SP_INIT);
        rst_n = 1'b1;
        sp_model = SP_INIT;
        @(negedge clk);
        do_push(1'b0, 1'b0, 8'h00);           // R2: registers cleared by reset

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule